// File: doc/BRIEF.md
# Floppy Controller Drive Output Control Register

This block holds the host-visible 8-bit control byte of a floppy disk controller. Software writes it through a small I/O port (offset 2 of the controller's window) and may read it back at the same offset. The stored byte drives the drive interface directly. Two bits form a binary drive number that is decoded into four one-hot select lines. Two bits switch the motors of drives 0 and 1. One active-low bit holds the rest of the controller in reset. One bit enables the DMA and interrupt pins.

How the DMA-enable bit acts depends on a static mode input. In PC/AT-style mode (mode 0), a cleared DMA enable puts the DMA request and interrupt pads into high impedance through exported output enables. It also masks the DMA acknowledge and terminal-count inputs. In PS/2-style mode (mode 1), those four pins stay live whatever the bit holds, and also while reset is asserted. A software reset through bit 2 leaves the register itself untouched.

Top module: `floppy_dor`

## Requirements
- R1: Hardware reset (rst high) clears all eight register bits to 0, so a read returns 0x00, drive 0 is selected and every motor output is low.
- R2: A write strobe (cs and wr_en high with addr equal to 2) stores wdata. A read strobe at offset 2 returns the stored byte on rdata in the same cycle. Bits 7 and 6 always read as 0.
- R3: A write to any other offset leaves the register unchanged. A read at any other offset, or with no read strobe, returns 0x00.
- R4: drv_sel is one-hot: bit n is high exactly when register bits [1:0] hold the binary value n.
- R5: motor[0] follows register bit 4 and motor[1] follows bit 5. motor[3:2] are always 0, whatever value is written. A drive select is not qualified by its motor bit.
- R6: ctl_reset is high while rst is high or register bit 2 is 0. Writing 0 and then 1 to bit 2 in back-to-back writes produces a reset pulse of one write period. The other bits of the register keep the values that were written.
- R7: In mode 0 with bit 3 clear, drq_oe and intr_oe are low, dack_n_out is forced to 1 and tc_out to 0, whatever dack_n_in and tc_in hold.
- R8: In mode 0 with bit 3 set, drq_oe and intr_oe are high, drq_out and intr_out follow drq_in and intr_in, and dack_n_out and tc_out follow their inputs.
- R9: In mode 1 the four DMA and interrupt paths behave as in R8 whatever bit 3 holds, including while rst is high. Bit 3 still clears to 0 on reset.
- R10: The register, and every output derived from it, changes on the clock edge that samples the write strobe. Before that edge the outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, active high, synchronous clear of the register |
| cs | input | 1 | Controller chip select |
| addr | input | 3 | Offset within the controller window |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (0 when not addressed) |
| mode_ps2 | input | 1 | 0 = PC/AT-style, 1 = PS/2-style pin gating |
| drq_in | input | 1 | DMA request from the controller core |
| intr_in | input | 1 | Interrupt from the controller core |
| dack_n_in | input | 1 | DMA acknowledge from the pad, active low |
| tc_in | input | 1 | Terminal count from the pad |
| drq_out | output | 1 | DMA request toward the pad |
| drq_oe | output | 1 | Output enable of the DMA request pad |
| intr_out | output | 1 | Interrupt toward the pad |
| intr_oe | output | 1 | Output enable of the interrupt pad |
| dack_n_out | output | 1 | Gated DMA acknowledge toward the core |
| tc_out | output | 1 | Gated terminal count toward the core |
| drv_sel | output | 4 | One-hot drive selects, active high |
| motor | output | 4 | Motor enables, active high |
| ctl_reset | output | 1 | Reset to the rest of the controller, active high |

## Verification
The hardest state to reach from the ports is the PS/2-style pin behaviour while hardware reset is held. There the DMA-enable bit is being cleared, yet the pins must stay live. The bench holds rst high in both modes and drives the core and pad inputs through all sixteen combinations during that time. A second hard case is a soft reset that changes nothing else. The bench sweeps all 256 written values, and for each one checks the readback, the decoded selects, the motors, the reset output and the gating in both modes. It also issues back-to-back clear and set writes to bit 2 and checks that the other bits survive.

// File: rtl/fdor_pkg.sv
package fdor_pkg;
  localparam int SEL_W   = 2;
  localparam int NUM_DRV = 1 << SEL_W;
  localparam int NUM_MOT = 4;
  localparam int LIVE_MOT = 2;

  typedef struct packed {
    logic [1:0]       mot_hi;   // motors 3..2, held at zero
    logic [1:0]       mot_lo;   // motors 1..0
    logic             dma_en;
    logic             run_n;    // 0 holds controller reset
    logic [SEL_W-1:0] sel;
  } dor_t;

  function automatic logic [NUM_DRV-1:0] sel_decode(logic [SEL_W-1:0] s);
    logic [NUM_DRV-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  function automatic dor_t sanitize(logic [7:0] w);
    dor_t r;
    r = dor_t'(w);
    r.mot_hi = 2'b00;
    return r;
  endfunction

  function automatic logic pins_live(logic ps2, logic dma_en);
    return ps2 | dma_en;
  endfunction
endpackage

// File: rtl/fdor_store.sv
module fdor_store
  import fdor_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output dor_t              dor_q
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic addr_hit;
  logic wr_hit;
  logic wr_miss;
  logic rd_hit;

  assign addr_hit = cs && (addr == OFFS);
  assign wr_hit   = addr_hit && wr_en;
  assign wr_miss  = wr_en && !wr_hit;
  assign rd_hit   = addr_hit && rd_en;

  always_ff @(posedge clk) begin
    if (rst) dor_q <= '0;
    else if (wr_hit) dor_q <= sanitize(wdata);
  end

  assign rdata = rd_hit ? dor_q : 8'h00;

  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (dor_q[5:0] == $past(wdata[5:0])));
  a_r3_other_offset: assert property (@(posedge clk) disable iff (rst)
    (wr_miss && !$past(rst)) |=> $stable(dor_q));
  a_r3_read_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |-> (rdata == 8'h00));
endmodule

// File: rtl/fdor_drive_outs.sv
module fdor_drive_outs
  import fdor_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  dor_t               dor_q,
  output logic [NUM_DRV-1:0] drv_sel,
  output logic [NUM_MOT-1:0] motor,
  output logic               ctl_reset
);
  logic [NUM_MOT-1:0] mot_bits;
  assign mot_bits = {dor_q.mot_hi, dor_q.mot_lo};

  assign drv_sel = sel_decode(dor_q.sel);

  for (genvar m = 0; m < NUM_MOT; m++) begin : g_mot
    if (m < LIVE_MOT) begin : g_live
      assign motor[m] = mot_bits[m];
    end else begin : g_dead
      assign motor[m] = 1'b0;
    end
  end

  assign ctl_reset = rst | ~dor_q.run_n;

  a_r4_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(drv_sel) == 1);
  a_r5_upper_motors_off: assert property (@(posedge clk) disable iff (rst)
    motor[3:2] == 2'b00);

  always_comb begin
    if (rst === 1'b1)
      a_r6_hw_reset_out: assert (ctl_reset);
  end
endmodule

// File: rtl/fdor_pin_gate.sv
module fdor_pin_gate
  import fdor_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mode_ps2,
  input  logic dma_en,
  input  logic drq_in,
  input  logic intr_in,
  input  logic dack_n_in,
  input  logic tc_in,
  output logic drq_out,
  output logic drq_oe,
  output logic intr_out,
  output logic intr_oe,
  output logic dack_n_out,
  output logic tc_out
);
  logic live;
  assign live = pins_live(mode_ps2, dma_en);

  assign drq_oe     = live;
  assign intr_oe    = live;
  assign drq_out    = live & drq_in;
  assign intr_out   = live & intr_in;
  assign dack_n_out = live ? dack_n_in : 1'b1;
  assign tc_out     = live & tc_in;

  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (!mode_ps2 && !dma_en) |-> (dack_n_out && !tc_out && !drq_oe && !intr_oe));

  always_comb begin
    if (mode_ps2 === 1'b1)
      a_r9_ps2_live: assert (drq_oe && intr_oe);
  end
endmodule

// File: rtl/floppy_dor.sv
module floppy_dor
  import fdor_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int REG_OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              mode_ps2,
  input  logic              drq_in,
  input  logic              intr_in,
  input  logic              dack_n_in,
  input  logic              tc_in,
  output logic              drq_out,
  output logic              drq_oe,
  output logic              intr_out,
  output logic              intr_oe,
  output logic              dack_n_out,
  output logic              tc_out,
  output logic [3:0]        drv_sel,
  output logic [3:0]        motor,
  output logic              ctl_reset
);
  dor_t dor_q;

  fdor_store #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_store (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .dor_q(dor_q)
  );

  fdor_drive_outs u_drv (
    .clk(clk), .rst(rst), .dor_q(dor_q),
    .drv_sel(drv_sel), .motor(motor), .ctl_reset(ctl_reset)
  );

  fdor_pin_gate u_gate (
    .clk(clk), .rst(rst), .mode_ps2(mode_ps2), .dma_en(dor_q.dma_en),
    .drq_in(drq_in), .intr_in(intr_in), .dack_n_in(dack_n_in), .tc_in(tc_in),
    .drq_out(drq_out), .drq_oe(drq_oe), .intr_out(intr_out), .intr_oe(intr_oe),
    .dack_n_out(dack_n_out), .tc_out(tc_out)
  );
endmodule

// File: tb/tb_floppy_dor.sv
`timescale 1ns/1ps
module tb_floppy_dor;
  logic clk = 0;
  logic rst, cs, wr_en, rd_en, mode_ps2;
  logic [2:0] addr;
  logic [7:0] wdata, rdata;
  logic drq_in, intr_in, dack_n_in, tc_in;
  logic drq_out, drq_oe, intr_out, intr_oe, dack_n_out, tc_out, ctl_reset;
  logic [3:0] drv_sel, motor;
  int checks = 0, errors = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  floppy_dor dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] v);
    @(negedge clk);
    cs = 1; wr_en = 1; addr = a; wdata = v;
    @(negedge clk);
    cs = 0; wr_en = 0;
  endtask

  function automatic logic [7:0] rd_now(logic [2:0] a);
    return 8'h00;
  endfunction

  task automatic readback(string req, logic [7:0] exp);
    cs = 1; rd_en = 1; addr = 3'd2; #1;
    chk(req, rdata, exp);
    cs = 0; rd_en = 0; #1;
  endtask

  task automatic check_outs(logic [7:0] m);
    logic [3:0] es;
    for (int i = 0; i < 4; i++) es[i] = (m % 4) == i;
    chk("R4", drv_sel, es);
    chk("R5", motor, {2'b00, m[5], m[4]});
    chk("R6", ctl_reset, !m[2]);
  endtask

  task automatic check_gate(logic ps2, logic de, logic inrst);
    logic live;
    live = ps2 || de;
    mode_ps2 = ps2;
    for (int c = 0; c < 16; c++) begin
      {drq_in, intr_in, dack_n_in, tc_in} = c[3:0];
      #1;
      if (!live) begin
        chk("R7", {drq_oe, intr_oe, dack_n_out, tc_out}, 4'b0010);
      end else begin
        chk(ps2 ? "R9" : "R8",
            {drq_oe, intr_oe, drq_out, intr_out, dack_n_out, tc_out},
            {2'b11, c[3], c[2], c[1], c[0]});
      end
    end
    if (inrst) chk("R9", ctl_reset, 1);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; cs = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; mode_ps2 = 0;
    drq_in = 0; intr_in = 0; dack_n_in = 1; tc_in = 0;
    repeat (2) @(negedge clk);
    readback("R1", 8'h00);
    chk("R1", {drv_sel, motor}, 8'h10);
    chk("R1", ctl_reset, 1);
    check_gate(0, 0, 1);   // PC/AT in reset: masked
    check_gate(1, 0, 1);   // PS/2 in reset: live
    mode_ps2 = 0;
    @(negedge clk); rst = 0;

    // full sweep of written values
    for (int v = 0; v < 256; v++) begin
      wr(3'd2, v[7:0]);
      model = {2'b00, v[5:0]};
      readback("R2", model);
      check_outs(model);
      check_gate(0, model[3], 0);
      check_gate(1, model[3], 0);
    end

    // other offsets ignored
    wr(3'd2, 8'h1d); model = 8'h1d;
    for (int a = 0; a < 8; a++) begin
      if (a != 2) begin
        wr(a[2:0], 8'he2);
        readback("R3", model);
        check_outs(model);
        cs = 1; rd_en = 1; addr = a[2:0]; #1;
        chk("R3", rdata, 8'h00);
        cs = 0; rd_en = 0;
      end
    end
    // write with cs low ignored
    @(negedge clk); wr_en = 1; addr = 3'd2; wdata = 8'h00;
    @(negedge clk); wr_en = 0;
    readback("R3", model);

    // R10 timing: outputs hold until the edge
    @(negedge clk); cs = 1; wr_en = 1; addr = 3'd2; wdata = 8'h3e; #1;
    chk("R10", drv_sel, 4'b0010);
    chk("R10", motor, 4'b0001);
    @(posedge clk); #1;
    chk("R10", drv_sel, 4'b0100);
    chk("R10", motor, 4'b0011);
    @(negedge clk); cs = 0; wr_en = 0;

    // R6 back-to-back soft reset pulse
    wr(3'd2, 8'h39);
    check_outs(8'h39);
    chk("R6", ctl_reset, 1);
    wr(3'd2, 8'h3d);
    chk("R6", ctl_reset, 0);
    readback("R6", 8'h3d);
    check_outs(8'h3d);

    // hardware reset again from non-zero state
    @(negedge clk); rst = 1; #1;
    chk("R6", ctl_reset, 1);
    @(negedge clk);
    readback("R1", 8'h00);
    check_gate(1, 0, 1);
    @(negedge clk); rst = 0; #1;
    chk("R6", ctl_reset, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule